// File: doc/BRIEF.md
# Spill/Fill NaT-Collection Hazard Checker

This block inspects one instruction group at a time and flags dependency hazards on the 64-bit NaT-collection register. Spill stores write one bit of that register, and fill loads read one bit. Whole-register move-to and move-from operations write or read all 64 bits at once.

Each slot of the group carries a valid bit, a qualifying-predicate value, an operation class and, for spill and fill, a 6-bit bit index. Slot order gives program order, with slot 0 first. Spill and fill operations are tracked bit by bit. A whole-register move conflicts with every active spill or fill in the same group.

The result is registered. It appears with a one-cycle report pulse after the group strobe. The result is a RAW flag, a WAW flag and the earliest offending pair of slot indices. A small controller has two states. S_IDLE waits for a strobe. S_REPORT raises the report pulse for one cycle. The transitions are: a strobe moves either state to S_REPORT, and a cycle without a strobe moves either state to S_IDLE.

Top module: `nat_hz_check`

## Requirements
- R1: `rpt_valid` is 1 in exactly the cycle after a cycle in which `grp_strobe` was 1. The result outputs are loaded on that same edge and hold their values until the next report.
- R2: A slot is active only when both `slot_valid` and `slot_pred` are 1. An inactive slot never takes part in a violation.
- R3: The 3-bit operation code is 1 for spill, 2 for fill, 3 for move-to, 4 for move-from, and 0 or 5 to 7 for other. An active spill in slot i followed by an active fill of the same 6-bit bit index in a later slot j is a RAW violation with older=i and younger=j.
- R4: Two active spills of the same bit index are a WAW violation.
- R5: None of the following is a violation: spills and fills of different bit indices, a fill followed by a later spill of the same bit index, or two fills of the same bit index.
- R6: An active spill or fill paired, in either order, with an active move-to or move-from is a violation. It is WAW when the pair is a spill and a move-to, and RAW otherwise. Pairs made only of moves or "other" operations are never violations.
- R7: `rpt_raw` is 1 when any RAW pair exists in the group. `rpt_waw` is 1 when any WAW pair exists. Both can be 1 together.
- R8: The reported pair is chosen over all violating pairs of either kind. The pair with the smallest younger slot wins, and ties go to the smallest older slot. A clean group reports older=0 and younger=0. A violating report always has older < younger.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_strobe | input | 1 | The slot inputs hold a group to check |
| slot_valid | input | N_SLOTS | Per-slot valid |
| slot_pred | input | N_SLOTS | Per-slot qualifying-predicate value |
| slot_op | input | 3*N_SLOTS | Per-slot operation code, slot k at bits [3k+2:3k] |
| slot_bit | input | 6*N_SLOTS | Per-slot bit index, slot k at bits [6k+5:6k] |
| rpt_valid | output | 1 | One-cycle report pulse |
| rpt_raw | output | 1 | RAW violation present |
| rpt_waw | output | 1 | WAW violation present |
| rpt_older | output | 3 | Older slot of the reported pair |
| rpt_younger | output | 3 | Younger slot of the reported pair |

## Verification
The assertions assume that `grp_strobe` and the slot inputs are steady around each rising edge. They also assume that a group fully lacking active slots must yield a clean report, whatever the operation codes say. The bench changes inputs only on falling edges. It raises the strobe for single cycles, and it changes slot contents between reports without a strobe, so that the hold behaviour is exercised without adding new groups. Every group is written by hand so that its expected pair follows directly from the ordering rule.

// File: rtl/nat_hz_pkg.sv
package nat_hz_pkg;
    typedef enum logic [2:0] {
        OP_OTHER = 3'd0,
        OP_SPILL = 3'd1,
        OP_FILL  = 3'd2,
        OP_MTO   = 3'd3,
        OP_MFROM = 3'd4
    } nat_op_e;

    typedef struct packed {
        logic spill;
        logic fill;
        logic mto;
        logic mfrom;
    } slot_role_t;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } rpt_state_e;
endpackage

// File: rtl/nat_hz_slot_dec.sv
module nat_hz_slot_dec
    import nat_hz_pkg::*;
(
    input  logic       valid,
    input  logic       pred,
    input  logic [2:0] op,
    output slot_role_t role
);
    logic live;

    always_comb begin
        live = valid & pred;
        role = '0;
        unique case (op)
            OP_SPILL: role.spill = live;
            OP_FILL:  role.fill  = live;
            OP_MTO:   role.mto   = live;
            OP_MFROM: role.mfrom = live;
            default:  role       = '0;
        endcase
    end
endmodule

// File: rtl/nat_hz_pair.sv
module nat_hz_pair
    import nat_hz_pkg::*;
#(
    parameter int BITW = 6
) (
    input  slot_role_t      older,
    input  slot_role_t      younger,
    input  logic [BITW-1:0] older_bit,
    input  logic [BITW-1:0] younger_bit,
    output logic            raw,
    output logic            waw
);
    logic same_bit;
    logic bit_op_o, bit_op_y, move_o, move_y;
    logic mixed, write_pair;

    always_comb begin
        same_bit   = (older_bit == younger_bit);
        bit_op_o   = older.spill | older.fill;
        bit_op_y   = younger.spill | younger.fill;
        move_o     = older.mto | older.mfrom;
        move_y     = younger.mto | younger.mfrom;
        mixed      = (bit_op_o & move_y) | (move_o & bit_op_y);
        write_pair = (older.spill & younger.mto) | (older.mto & younger.spill);
        waw = (older.spill & younger.spill & same_bit) | (mixed & write_pair);
        raw = (older.spill & younger.fill & same_bit) | (mixed & ~write_pair);
    end
endmodule

// File: rtl/nat_hz_check.sv
module nat_hz_check
    import nat_hz_pkg::*;
#(
    parameter int N_SLOTS  = 6,
    parameter int NAT_BITS = 64,
    localparam int BITW    = $clog2(NAT_BITS),
    localparam int IDXW    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grp_strobe,
    input  logic [N_SLOTS-1:0]      slot_valid,
    input  logic [N_SLOTS-1:0]      slot_pred,
    input  logic [3*N_SLOTS-1:0]    slot_op,
    input  logic [BITW*N_SLOTS-1:0] slot_bit,
    output logic                    rpt_valid,
    output logic                    rpt_raw,
    output logic                    rpt_waw,
    output logic [IDXW-1:0]         rpt_older,
    output logic [IDXW-1:0]         rpt_younger
);
    slot_role_t role [N_SLOTS];
    logic [N_SLOTS-1:0] raw_m [N_SLOTS];
    logic [N_SLOTS-1:0] waw_m [N_SLOTS];

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_dec
        nat_hz_slot_dec u_dec (
            .valid (slot_valid[k]),
            .pred  (slot_pred[k]),
            .op    (slot_op[3*k +: 3]),
            .role  (role[k])
        );
    end

    // raw_m[j][i] / waw_m[j][i]: conflict between older slot i and younger slot j
    for (genvar j = 0; j < N_SLOTS; j++) begin : g_young
        for (genvar i = 0; i < N_SLOTS; i++) begin : g_old
            if (i < j) begin : g_cmp
                nat_hz_pair #(.BITW(BITW)) u_pair (
                    .older       (role[i]),
                    .younger     (role[j]),
                    .older_bit   (slot_bit[BITW*i +: BITW]),
                    .younger_bit (slot_bit[BITW*j +: BITW]),
                    .raw         (raw_m[j][i]),
                    .waw         (waw_m[j][i])
                );
            end else begin : g_none
                assign raw_m[j][i] = 1'b0;
                assign waw_m[j][i] = 1'b0;
            end
        end
    end

    logic            any_raw, any_waw, found;
    logic [IDXW-1:0] pick_old, pick_young;

    always_comb begin
        any_raw    = 1'b0;
        any_waw    = 1'b0;
        found      = 1'b0;
        pick_old   = '0;
        pick_young = '0;
        for (int j = 0; j < N_SLOTS; j++) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                any_raw = any_raw | raw_m[j][i];
                any_waw = any_waw | waw_m[j][i];
                if (!found && (raw_m[j][i] || waw_m[j][i])) begin
                    found      = 1'b1;
                    pick_old   = IDXW'(i);
                    pick_young = IDXW'(j);
                end
            end
        end
    end

    rpt_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            S_IDLE:   state_d = grp_strobe ? S_REPORT : S_IDLE;
            S_REPORT: state_d = grp_strobe ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_raw     <= 1'b0;
            rpt_waw     <= 1'b0;
            rpt_older   <= '0;
            rpt_younger <= '0;
        end else if (grp_strobe) begin
            rpt_raw     <= any_raw;
            rpt_waw     <= any_waw;
            rpt_older   <= pick_old;
            rpt_younger <= pick_young;
        end
    end

    assign rpt_valid = (state_q == S_REPORT);
endmodule

// File: rtl/nat_hz_check_sva.sv
module nat_hz_check_sva #(
    parameter int N_SLOTS = 6,
    parameter int IDXW    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               grp_strobe,
    input logic [N_SLOTS-1:0] slot_valid,
    input logic [N_SLOTS-1:0] slot_pred,
    input logic               rpt_valid,
    input logic               rpt_raw,
    input logic               rpt_waw,
    input logic [IDXW-1:0]    rpt_older,
    input logic [IDXW-1:0]    rpt_younger
);
    // R1
    pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_strobe |=> rpt_valid);

    // R1
    no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_strobe |=> !rpt_valid);

    // R1
    hold_between_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_valid |-> ($stable(rpt_raw) && $stable(rpt_waw)
                        && $stable(rpt_older) && $stable(rpt_younger)));

    // R2
    idle_group_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_strobe && ((slot_valid & slot_pred) == '0)) |=> (!rpt_raw && !rpt_waw));

    // R8
    pair_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && (rpt_raw || rpt_waw)) |-> (rpt_older < rpt_younger));

    // R8
    clean_pair_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_raw && !rpt_waw) |-> (rpt_older == '0 && rpt_younger == '0));
endmodule

bind nat_hz_check nat_hz_check_sva #(.N_SLOTS(N_SLOTS), .IDXW(IDXW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_strobe  (grp_strobe),
    .slot_valid  (slot_valid),
    .slot_pred   (slot_pred),
    .rpt_valid   (rpt_valid),
    .rpt_raw     (rpt_raw),
    .rpt_waw     (rpt_waw),
    .rpt_older   (rpt_older),
    .rpt_younger (rpt_younger)
);

// File: tb/test_nat_hz_check.sv
module test_nat_hz_check;
    localparam int N = 6;
    localparam logic [2:0] SP = 3'd1, FL = 3'd2, MT = 3'd3, MF = 3'd4, OT = 3'd0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_strobe = 1'b0;
    logic [N-1:0] v, p;
    logic [2:0] o [N];
    logic [5:0] b [N];
    logic [3*N-1:0] op_flat;
    logic [6*N-1:0] bit_flat;
    logic rpt_valid, rpt_raw, rpt_waw;
    logic [2:0] rpt_older, rpt_younger;
    int ntot = 0, nbad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            op_flat[3*k +: 3]  = o[k];
            bit_flat[6*k +: 6] = b[k];
        end
    end

    nat_hz_check i_nat_hz_check (
        .clk(clk), .rst_n(rst_n), .grp_strobe(grp_strobe),
        .slot_valid(v), .slot_pred(p), .slot_op(op_flat), .slot_bit(bit_flat),
        .rpt_valid(rpt_valid), .rpt_raw(rpt_raw), .rpt_waw(rpt_waw),
        .rpt_older(rpt_older), .rpt_younger(rpt_younger)
    );

    task automatic clear_slots();
        v = '0; p = '0;
        for (int k = 0; k < N; k++) begin o[k] = OT; b[k] = '0; end
    endtask

    task automatic put(input int k, input logic [2:0] op, input logic [5:0] bi);
        v[k] = 1'b1; p[k] = 1'b1; o[k] = op; b[k] = bi;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        ntot++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rpt(input string tag, input bit er, input bit ew, input int eo, input int ey);
        chk({tag, " raw"}, int'(rpt_raw), int'(er));
        chk({tag, " waw"}, int'(rpt_waw), int'(ew));
        chk({tag, " older"}, int'(rpt_older), eo);
        chk({tag, " younger"}, int'(rpt_younger), ey);
    endtask

    // strobe one cycle, then sample after the capturing edge (R1)
    task automatic send(input string tag, input bit er, input bit ew, input int eo, input int ey);
        @(negedge clk) grp_strobe = 1'b1;
        @(negedge clk) grp_strobe = 1'b0;
        chk({tag, " R1 pulse"}, int'(rpt_valid), 1);
        chk_rpt(tag, er, ew, eo, ey);
    endtask

    task automatic t_reset();
        chk("R9 valid", int'(rpt_valid), 0);
        chk_rpt("R9 reset", 0, 0, 0, 0);
    endtask

    task automatic t_clean_bits();
        clear_slots();
        put(0, SP, 6'd1); put(1, SP, 6'd2); put(2, FL, 6'd4);
        put(3, SP, 6'd3); put(4, FL, 6'd5); put(5, FL, 6'd0);
        send("R5 distinct bits", 0, 0, 0, 0);
        clear_slots();
        put(0, FL, 6'd7); put(2, SP, 6'd7); put(3, FL, 6'd9); put(5, FL, 6'd9);
        send("R5 fill-then-spill and fill pair", 0, 0, 0, 0);
    endtask

    task automatic t_raw();
        clear_slots();
        put(1, SP, 6'd9); put(2, FL, 6'd8); put(3, FL, 6'd9);
        send("R3 spill then fill", 1, 0, 1, 3);
    endtask

    task automatic t_waw();
        clear_slots();
        put(0, SP, 6'd63); put(2, FL, 6'd1); put(4, SP, 6'd63);
        send("R4 spill spill", 0, 1, 0, 4);
    endtask

    task automatic t_pred();
        clear_slots();
        put(0, SP, 6'd63); put(4, SP, 6'd63); p[4] = 1'b0;
        send("R2 predicate off", 0, 0, 0, 0);
        clear_slots();
        put(1, SP, 6'd12); put(3, FL, 6'd12); v[1] = 1'b0;
        put(5, MT, 6'd0); p[5] = 1'b0;
        send("R2 invalid slot", 0, 0, 0, 0);
    endtask

    task automatic t_moves();
        clear_slots();
        put(0, MF, 6'd0); put(2, SP, 6'd5);
        send("R6 move-from then spill", 1, 0, 0, 2);
        clear_slots();
        put(1, MT, 6'd0); put(3, FL, 6'd5);
        send("R6 move-to then fill", 1, 0, 1, 3);
        clear_slots();
        put(0, SP, 6'd33); put(5, MT, 6'd0);
        send("R6 spill then move-to", 0, 1, 0, 5);
        clear_slots();
        put(0, MT, 6'd0); put(1, MF, 6'd0); put(2, 3'd7, 6'd1); put(3, MT, 6'd2); put(4, 3'd5, 6'd1);
        send("R6 moves and others only", 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        clear_slots();
        put(0, SP, 6'd3); put(1, SP, 6'd4); put(2, SP, 6'd4); put(3, FL, 6'd3);
        send("R7 both flags, R8 earliest", 1, 1, 1, 2);
        clear_slots();
        put(0, MF, 6'd0); put(1, MT, 6'd0); put(3, FL, 6'd12);
        send("R8 tie older", 1, 0, 0, 3);
    endtask

    task automatic t_hold();
        clear_slots();
        put(0, SP, 6'd20); put(1, FL, 6'd20);
        send("R1 load", 1, 0, 0, 1);
        clear_slots();
        put(0, SP, 6'd8); put(4, SP, 6'd8);
        @(negedge clk);
        chk("R1 pulse ends", int'(rpt_valid), 0);
        repeat (2) @(negedge clk);
        chk_rpt("R1 hold", 1, 0, 0, 1);
    endtask

    initial begin
        clear_slots();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean_bits();
        t_raw();
        t_waw();
        t_pred();
        t_moves();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            ntot++; nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end
endmodule